// File: doc/BRIEF.md
# ANSI terminal control-sequence decoder

This block sits between a byte-wide display write port and a text-screen controller. Each byte offered on the valid/ready input is classified in the cycle it is accepted. A printable byte becomes a print command. A few single-byte controls become cursor or screen commands. Escape sequences of the select-graphic-rendition form (ESC, '[', decimal parameters, 'm') change the foreground colour.

All commands are one-cycle pulses, registered, and appear in the cycle after the byte is accepted. Parameters are gathered as ASCII decimal digits and applied one at a time, in order.

The parameter `GLOBAL_COLOUR` sets how colour reaches the screen:
- At 1, every applied colour is issued as a command that repaints the whole display.
- At 0, no command is issued. The new colour only rides along with later print commands.

In both modes the current attribute is visible on `fg_colour_o`.

Top module: `ansi_seq_decoder`

## Requirements
- R1: After reset, `cmd_valid_o` is low, `fg_colour_o` equals `DEFAULT_FG` (7), and `byte_ready_o` is high.
- R2: Outside a sequence, a byte from 0x20 to 0x7E produces one pulse of `cmd_valid_o` in the next cycle. The pulse carries `cmd_kind_o`=1 (print), `cmd_char_o`=the byte, and `cmd_colour_o`=the attribute in force before the byte.
- R3: Outside a sequence, byte 0x0D gives kind 2 (carriage return), 0x0A gives kind 3 (line feed), and 0x0C gives kind 4 (clear screen). Each is a single pulse in the next cycle.
- R4: Outside a sequence, any other byte except ESC (0x1B) is ignored. This covers other bytes below 0x20, 0x7F, and bytes of 0x80 and above. No command results and the attribute does not change.
- R5: ESC, '[' (0x5B), then a decimal parameter from 30 to 37, then 'm' (0x6D) sets the attribute to the parameter minus 30. For example, 33 selects code 3.
- R6: Parameters are separated by ';' (0x3B). Each one is applied, in arrival order, when its ';' or the final 'm' is accepted.
- R7: A parameter of 0, or an empty parameter (including an empty list, as in ESC '[' 'm'), restores `DEFAULT_FG`.
- R8: Digit accumulation saturates at 99. Parameters other than 0 and 30 to 37 have no effect.
- R9: If a byte other than '[' follows ESC, the decoder returns to idle. That byte produces no command.
- R10: Inside a sequence, any byte that is not a digit, ';' or 'm' ends the sequence without effect. The pending parameter is dropped, and parameters already applied remain applied.
- R11: With `GLOBAL_COLOUR`=1, each effective colour change emits kind 5 with the new code on `cmd_colour_o`. With `GLOBAL_COLOUR`=0, no kind 5 is emitted, and the new code appears on later print commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_valid_i | input | 1 | Input byte offered |
| byte_data_i | input | 8 | Input byte |
| byte_ready_o | output | 1 | Decoder accepts a byte this cycle |
| cmd_valid_o | output | 1 | One-cycle command strobe |
| cmd_kind_o | output | 3 | 1 print, 2 CR, 3 LF, 4 clear, 5 colour |
| cmd_char_o | output | 8 | Character for print commands |
| cmd_colour_o | output | CW | Colour code for print and colour commands |
| fg_colour_o | output | CW | Current foreground attribute |

## Verification
The bench builds two copies of the block side by side and drives both with the same byte stream. One copy uses `GLOBAL_COLOUR`=1 and the other `GLOBAL_COLOUR`=0, both with the default 3-bit colour, `DEFAULT_FG`=7 and a saturation limit of 99. Running both copies together shows the same sequence issuing repaint commands in one mode and only retagging later characters in the other. The stream includes multi-parameter lists, empty parameters, values that saturate the digit accumulator, aborted escapes and foreign final bytes, so that ordering and dropping of parameters are observed in both modes.

// File: rtl/ansi_dec_pkg.sv
package ansi_dec_pkg;
  typedef enum logic [2:0] {
    CMD_NONE   = 3'd0,
    CMD_PRINT  = 3'd1,
    CMD_CR     = 3'd2,
    CMD_LF     = 3'd3,
    CMD_CLEAR  = 3'd4,
    CMD_COLOUR = 3'd5
  } cmd_kind_e;

  typedef enum logic [1:0] {
    ST_TEXT = 2'd0,
    ST_ESC  = 2'd1,
    ST_CSI  = 2'd2
  } dec_state_e;

  localparam logic [7:0] CH_ESC  = 8'h1B;
  localparam logic [7:0] CH_LBR  = 8'h5B;
  localparam logic [7:0] CH_SEP  = 8'h3B;
  localparam logic [7:0] CH_SGR  = 8'h6D;
  localparam logic [7:0] CH_CR   = 8'h0D;
  localparam logic [7:0] CH_LF   = 8'h0A;
  localparam logic [7:0] CH_FF   = 8'h0C;
endpackage

// File: rtl/ansi_param_acc.sv
module ansi_param_acc #(
  parameter int MAX_VAL = 99,
  parameter int PW      = $clog2(MAX_VAL + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          digit_valid_i,
  input  logic [3:0]    digit_i,
  output logic [PW-1:0] val_o
);
  localparam int XW = PW + 4;

  logic [PW-1:0] val_q;
  logic [XW-1:0] ext;

  always_comb begin
    ext = XW'(val_q) * XW'(10) + XW'(digit_i);
    if (ext > XW'(MAX_VAL)) ext = XW'(MAX_VAL);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            val_q <= '0;
    else if (clr_i)         val_q <= '0;
    else if (digit_valid_i) val_q <= ext[PW-1:0];
  end

  assign val_o = val_q;

  a_r8_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(val_q) <= MAX_VAL);
  a_r8_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> val_q == '0);
endmodule

// File: rtl/ansi_colour_sel.sv
module ansi_colour_sel #(
  parameter int CW         = 3,
  parameter int PW         = 7,
  parameter int DEFAULT_FG = 7,
  parameter int BASE       = 30
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          apply_i,
  input  logic [PW-1:0] param_i,
  output logic [CW-1:0] attr_o,
  output logic          chg_valid_o,
  output logic [CW-1:0] chg_colour_o
);
  localparam int NCOL = 1 << CW;

  logic [CW-1:0] attr_q;
  logic          hit;
  logic [CW-1:0] code;

  always_comb begin
    hit  = 1'b0;
    code = CW'(DEFAULT_FG);
    if (param_i == '0) begin
      hit = 1'b1;
    end else if (32'(param_i) >= BASE && 32'(param_i) < BASE + NCOL) begin
      hit  = 1'b1;
      code = CW'(32'(param_i) - BASE);
    end
  end

  assign chg_valid_o  = apply_i && hit;
  assign chg_colour_o = code;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          attr_q <= CW'(DEFAULT_FG);
    else if (chg_valid_o) attr_q <= code;
  end

  assign attr_o = attr_q;

  a_r8_attr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !apply_i |=> $stable(attr_o));
  a_r6_attr_takes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_valid_o |=> attr_o == $past(chg_colour_o));
endmodule

// File: rtl/ansi_seq_decoder.sv
module ansi_seq_decoder
  import ansi_dec_pkg::*;
#(
  parameter int GLOBAL_COLOUR = 1,
  parameter int CW            = 3,
  parameter int DEFAULT_FG    = 7,
  parameter int PARAM_MAX     = 99
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          byte_valid_i,
  input  logic [7:0]    byte_data_i,
  output logic          byte_ready_o,
  output logic          cmd_valid_o,
  output logic [2:0]    cmd_kind_o,
  output logic [7:0]    cmd_char_o,
  output logic [CW-1:0] cmd_colour_o,
  output logic [CW-1:0] fg_colour_o
);
  localparam int PW = $clog2(PARAM_MAX + 1);

  dec_state_e    st_q, st_d;
  logic          acc_clr, dig_v, apply;
  logic [PW-1:0] param;
  logic [CW-1:0] attr, chg_col;
  logic          chg_v, col_evt;
  logic          is_digit, accept;
  cmd_kind_e     kind_d;
  logic          cmd_v_q;
  cmd_kind_e     kind_q;
  logic [7:0]    char_q;
  logic [CW-1:0] col_q;

  assign byte_ready_o = 1'b1;
  assign accept       = byte_valid_i && byte_ready_o;
  assign is_digit     = byte_data_i >= 8'h30 && byte_data_i <= 8'h39;

  always_comb begin
    st_d    = st_q;
    acc_clr = 1'b0;
    dig_v   = 1'b0;
    apply   = 1'b0;
    kind_d  = CMD_NONE;
    if (accept) begin
      unique case (st_q)
        ST_TEXT: begin
          if (byte_data_i == CH_ESC)                          st_d   = ST_ESC;
          else if (byte_data_i == CH_CR)                      kind_d = CMD_CR;
          else if (byte_data_i == CH_LF)                      kind_d = CMD_LF;
          else if (byte_data_i == CH_FF)                      kind_d = CMD_CLEAR;
          else if (byte_data_i >= 8'h20 && byte_data_i <= 8'h7E) kind_d = CMD_PRINT;
        end
        ST_ESC: begin
          acc_clr = 1'b1;
          st_d    = (byte_data_i == CH_LBR) ? ST_CSI : ST_TEXT;
        end
        ST_CSI: begin
          if (is_digit) begin
            dig_v = 1'b1;
          end else if (byte_data_i == CH_SEP) begin
            apply = 1'b1; acc_clr = 1'b1;
          end else if (byte_data_i == CH_SGR) begin
            apply = 1'b1; acc_clr = 1'b1; st_d = ST_TEXT;
          end else begin
            acc_clr = 1'b1; st_d = ST_TEXT;
          end
        end
        default: st_d = ST_TEXT;
      endcase
    end
    if (col_evt) kind_d = CMD_COLOUR;
  end

  ansi_param_acc #(.MAX_VAL(PARAM_MAX), .PW(PW)) u_acc (
    .clk_i, .rst_ni,
    .clr_i        (acc_clr),
    .digit_valid_i(dig_v),
    .digit_i      (byte_data_i[3:0]),
    .val_o        (param)
  );

  ansi_colour_sel #(.CW(CW), .PW(PW), .DEFAULT_FG(DEFAULT_FG)) u_col (
    .clk_i, .rst_ni,
    .apply_i     (apply),
    .param_i     (param),
    .attr_o      (attr),
    .chg_valid_o (chg_v),
    .chg_colour_o(chg_col)
  );

  generate
    if (GLOBAL_COLOUR != 0) begin : g_global
      assign col_evt = chg_v;
    end else begin : g_per_char
      assign col_evt = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_TEXT;
      cmd_v_q <= 1'b0;
      kind_q  <= CMD_NONE;
      char_q  <= '0;
      col_q   <= CW'(DEFAULT_FG);
    end else begin
      st_q    <= st_d;
      cmd_v_q <= kind_d != CMD_NONE;
      kind_q  <= kind_d;
      char_q  <= byte_data_i;
      col_q   <= col_evt ? chg_col : attr;
    end
  end

  assign cmd_valid_o  = cmd_v_q;
  assign cmd_kind_o   = kind_q;
  assign cmd_char_o   = char_q;
  assign cmd_colour_o = col_q;
  assign fg_colour_o  = attr;

  a_r2_cmd_from_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> $past(byte_valid_i));
  a_r2_print_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_kind_o == CMD_PRINT) |-> (cmd_char_o >= 8'h20 && cmd_char_o <= 8'h7E));
  a_r11_mode_kind: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_kind_o == CMD_COLOUR) |-> (GLOBAL_COLOUR != 0));
  a_r9_esc_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && st_q == ST_ESC) |=> !cmd_valid_o);
endmodule

// File: tb/sim_ansi_seq_decoder.sv
module sim_ansi_seq_decoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bv = 1'b0;
  logic [7:0] bd = 8'h00;
  always #2.5 clk = ~clk;

  logic g_rdy, g_v, p_rdy, p_v;
  logic [2:0] g_k, p_k, g_c, p_c, g_fg, p_fg;
  logic [7:0] g_ch, p_ch;

  ansi_seq_decoder #(.GLOBAL_COLOUR(1)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .byte_valid_i(bv), .byte_data_i(bd),
    .byte_ready_o(g_rdy), .cmd_valid_o(g_v), .cmd_kind_o(g_k), .cmd_char_o(g_ch),
    .cmd_colour_o(g_c), .fg_colour_o(g_fg));
  ansi_seq_decoder #(.GLOBAL_COLOUR(0)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .byte_valid_i(bv), .byte_data_i(bd),
    .byte_ready_o(p_rdy), .cmd_valid_o(p_v), .cmd_kind_o(p_k), .cmd_char_o(p_ch),
    .cmd_colour_o(p_c), .fg_colour_o(p_fg));

  int total = 0, bad = 0, cyc = 0;
  int st[2], acc[2], attr[2];

  task automatic check(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model(input int m, input logic [7:0] b, output int v, output int k,
                       output int c, output int col);
    int nc;
    v = 0; k = 0; c = 0; col = attr[m];
    if (st[m] == 0) begin
      if (b == 8'h1B) st[m] = 1;
      else if (b == 8'h0D) begin v = 1; k = 2; end
      else if (b == 8'h0A) begin v = 1; k = 3; end
      else if (b == 8'h0C) begin v = 1; k = 4; end
      else if (b >= 8'h20 && b <= 8'h7E) begin v = 1; k = 1; c = b; end
    end else if (st[m] == 1) begin
      acc[m] = 0;
      st[m] = (b == 8'h5B) ? 2 : 0;
    end else begin
      if (b >= 8'h30 && b <= 8'h39) begin
        acc[m] = acc[m] * 10 + (b - 8'h30);
        if (acc[m] > 99) acc[m] = 99;
      end else if (b == 8'h3B || b == 8'h6D) begin
        nc = -1;
        if (acc[m] == 0) nc = 7;
        else if (acc[m] >= 30 && acc[m] <= 37) nc = acc[m] - 30;
        if (nc >= 0) begin
          attr[m] = nc;
          if (m == 0) begin v = 1; k = 5; col = nc; end
        end
        acc[m] = 0;
        if (b == 8'h6D) st[m] = 0;
      end else begin
        acc[m] = 0; st[m] = 0;
      end
    end
  endtask

  task automatic cmp(string tag, int m, int v, int k, int c, int col);
    int av, ak, ac, acol, afg, ach;
    string nm;
    nm  = (m == 0) ? "glob" : "char";
    av  = (m == 0) ? int'(g_v)  : int'(p_v);
    ak  = (m == 0) ? int'(g_k)  : int'(p_k);
    ach = (m == 0) ? int'(g_ch) : int'(p_ch);
    acol= (m == 0) ? int'(g_c)  : int'(p_c);
    afg = (m == 0) ? int'(g_fg) : int'(p_fg);
    check(tag, {nm, " valid"}, av, v);
    if (v) begin
      check(tag, {nm, " kind"}, ak, k);
      if (k == 1) check(tag, {nm, " char"}, ach, c);
      if (k == 1 || k == 5) check(tag, {nm, " colour"}, acol, col);
    end
    check(tag, {nm, " fg"}, afg, attr[m]);
  endtask

  task automatic send(input logic [7:0] b, input string tag);
    int v0, k0, c0, l0, v1, k1, c1, l1;
    bv = 1'b1; bd = b;
    model(0, b, v0, k0, c0, l0);
    model(1, b, v1, k1, c1, l1);
    @(negedge clk);
    bv = 1'b0;
    cmp(tag, 0, v0, k0, c0, l0);
    cmp(tag, 1, v1, k1, c1, l1);
  endtask

  task automatic send_str(input string s, input string tag);
    for (int i = 0; i < s.len(); i++) send(s[i], tag);
  endtask

  task automatic idle(input string tag);
    @(negedge clk);
    cmp(tag, 0, 0, 0, 0, 0);
    cmp(tag, 1, 0, 0, 0, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        bad++; total++;
        $display("FAIL watchdog R1 actual=%0d expected=<100000", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    for (int m = 0; m < 2; m++) begin st[m] = 0; acc[m] = 0; attr[m] = 7; end
    repeat (3) @(negedge clk);
    check("R1", "glob valid", int'(g_v), 0);
    check("R1", "char valid", int'(p_v), 0);
    check("R1", "glob fg", int'(g_fg), 7);
    check("R1", "char fg", int'(p_fg), 7);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "ready", int'(g_rdy & p_rdy), 1);
    idle("R1");
    send_str("Hi ~", "R2");
    send(8'h0D, "R3"); send(8'h0A, "R3"); send(8'h0C, "R3");
    send(8'h07, "R4"); send(8'h00, "R4"); send(8'h7F, "R4"); send(8'h80, "R4"); send(8'hFF, "R4");
    idle("R4");
    send(8'h1B, "R5"); send_str("[33m", "R5"); send_str("Y", "R11");
    send(8'h1B, "R6"); send_str("[31;32;35m", "R6"); send_str("a", "R11");
    send(8'h1B, "R7"); send_str("[m", "R7"); send_str("b", "R7");
    send(8'h1B, "R7"); send_str("[34;0m", "R7");
    send(8'h1B, "R7"); send_str("[;34m", "R7"); send_str("c", "R11");
    send(8'h1B, "R8"); send_str("[999m", "R8");
    send(8'h1B, "R8"); send_str("[3036m", "R8");
    send(8'h1B, "R8"); send_str("[1;38;29m", "R8"); send_str("d", "R8");
    send(8'h1B, "R9"); send_str("X", "R9"); send_str("e", "R9");
    send(8'h1B, "R9"); send(8'h1B, "R9"); send_str("f", "R9");
    send(8'h1B, "R10"); send_str("[36H", "R10"); send_str("g", "R10");
    send(8'h1B, "R10"); send_str("[35;36J", "R10"); send_str("h", "R10");
    send(8'h1B, "R10"); send_str("[30", "R10"); send(8'h0D, "R10"); send_str("i", "R10");
    send(8'h1B, "R5"); send_str("[37m", "R5"); send(8'h1B, "R5"); send_str("[30m", "R5");
    send_str("z", "R11");
    idle("R2");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule